// File: doc/BRIEF.md
# Firmware Write-Protect Control Register

This block is a single 32-bit memory-mapped control register. It decides whether the firmware flash region may be written. Software writes it through a simple port made of a byte address, write data and a write enable. Each access also carries two sideband bits: one says whether the access comes from privileged (system-management) mode, and one is the bus protection attribute. The register value is always visible on a read-data output. Two further outputs are a combinational write-permit for the firmware region and a level interrupt request to the privileged handler.

A software-settable lock stops non-privileged code from lifting the write protection. Only platform reset clears the lock. When the lock-interrupt enable input is high, a non-privileged attempt that the lock blocks sets a sticky status bit. That bit drives the interrupt request until the handler writes 1 to clear it. The register also stores a two-bit read-policy field for the flash controller and rejects the one illegal code of that field.

Top module: `fwProtReg`

## Requirements
- R1: After platform reset (`rstN` low) the register reads 0x00000020, `irqReq` is 0 and `fwWritePermit` is 0.
- R2: Bits 31:7 and bit 4 always read 0, and writes to them are ignored.
- R3: Bit 1 (lock) is set by writing 1 to it. Writing 0 never clears it; only reset does.
- R4: Bit 0 (protect-disable) may move from 0 to 1 on any write of 1 while the lock is clear. While the lock is set, only a write with `privMode`=1 moves it from 0 to 1; a non-privileged attempt leaves it at 0. The lock value used is the one held before the write.
- R5: Writing 0 to bit 0 clears it in every mode, locked or not.
- R6: Bit 5 (privileged-only enable, reset value 1) takes the written value while the lock is clear and holds its value while the lock is set.
- R7: Bit 6 (blocked-attempt status) is set when a write blocked under R4 occurs with `lockIrqEn`=1. It is not set when `lockIrqEn`=0 or when the lock is clear.
- R8: `irqReq` equals bit 6. Writing 1 to bit 6 clears it and writing 0 leaves it unchanged. If a write both clears bit 6 and triggers a new blocked attempt, the status stays set.
- R9: `fwWritePermit` = bit0 AND (NOT bit5 OR `protAttr`). While bit 5 is 0, `protAttr` has no effect.
- R10: Bits 3:2 (read policy) take the written value unless it is 2'b11. That code is rejected and the old value is kept.
- R11: Writes with `wrEn`=0, or at an address other than `REG_OFF` (default 0xFC), change nothing.
- R12: A blocked protect-disable attempt does not stop the other fields in the same write from updating under their own rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Platform reset, active low, asynchronous |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | 32 | Write data |
| privMode | input | 1 | Access comes from privileged mode |
| protAttr | input | 1 | Bus protection attribute of the firmware write |
| lockIrqEn | input | 1 | Enable for blocked-attempt status/interrupt |
| regValue | output | 32 | Current register contents |
| fwWritePermit | output | 1 | Firmware-region write allowed |
| irqReq | output | 1 | Level interrupt to the privileged handler |

## Verification
The bench targets the following corner cases, with the wrong behaviour each would expose:
- **Lock set and protect-disable set in the same write.** A design that samples the new lock would block or permit the wrong attempt.
- **Status clear and new blocked attempt in the same write.** A design that gives the clear priority would drop an interrupt.
- **A write of 0 to the status bit, and a write of 0 to the lock.** Treating either as a plain store would lose a sticky bit.
- **The illegal read-policy code, and a write of 0 to protect-disable while locked.** A wrong design would store the illegal code or refuse the clear.

A long pseudo-random sweep against an arithmetic model also covers wrong-address writes, `protAttr` toggling under both bit-5 values, and periodic resets.

// File: rtl/fwProtPkg.sv
package fwProtPkg;
  localparam int DATA_W = 32;
  localparam int WPD_B  = 0;
  localparam int LOCK_B = 1;
  localparam int CFG_LO = 2;
  localparam int CFG_HI = 3;
  localparam int PRIV_B = 5;
  localparam int STS_B  = 6;
  localparam logic [1:0] CFG_BAD = 2'b11;
  localparam logic [DATA_W-1:0] RESET_VAL = 32'h0000_0020;

  typedef struct packed {
    logic       wpdSet;
    logic       wpdClr;
    logic       lockSet;
    logic       privLoad;
    logic       privVal;
    logic       cfgLoad;
    logic [1:0] cfgVal;
    logic       stsSet;
    logic       stsClr;
  } ctlStrobe_t;
endpackage

// File: rtl/fwProtCtl.sv
module fwProtCtl
  import fwProtPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              privMode,
  input  logic              lockIrqEn,
  input  logic              wpdQ,
  input  logic              lockQ,
  output ctlStrobe_t        strobe
);
  logic hit;
  logic wantSet;
  logic blocked;

  always_comb begin
    hit     = wrEn && (addr == REG_OFF);
    wantSet = hit && wrData[WPD_B] && !wpdQ;
    blocked = wantSet && lockQ && !privMode;

    strobe          = '0;
    strobe.wpdSet   = wantSet && !blocked;
    strobe.wpdClr   = hit && !wrData[WPD_B];
    strobe.lockSet  = hit && wrData[LOCK_B];
    strobe.privLoad = hit && !lockQ;
    strobe.privVal  = wrData[PRIV_B];
    strobe.cfgLoad  = hit && (wrData[CFG_HI:CFG_LO] != CFG_BAD);
    strobe.cfgVal   = wrData[CFG_HI:CFG_LO];
    strobe.stsSet   = blocked && lockIrqEn;
    strobe.stsClr   = hit && wrData[STS_B];
  end

  // R5: protect-disable is never told to set and clear at once
  assert_wpd_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wpdSet && strobe.wpdClr));
  // R7: a status event only ever comes from a locked register
  assert_sts_needs_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stsSet |-> (lockQ && !privMode));
endmodule

// File: rtl/fwProtDp.sv
module fwProtDp
  import fwProtPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              protAttr,
  output logic [DATA_W-1:0] regValue,
  output logic              fwWritePermit,
  output logic              irqReq,
  output logic              wpdQ,
  output logic              lockQ
);
  logic       privQ;
  logic [1:0] cfgQ;
  logic       stsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpdQ  <= 1'b0;
      lockQ <= 1'b0;
      privQ <= RESET_VAL[PRIV_B];
      cfgQ  <= 2'b00;
      stsQ  <= 1'b0;
    end else begin
      if (strobe.wpdSet)       wpdQ <= 1'b1;
      else if (strobe.wpdClr)  wpdQ <= 1'b0;
      if (strobe.lockSet)      lockQ <= 1'b1;
      if (strobe.privLoad)     privQ <= strobe.privVal;
      if (strobe.cfgLoad)      cfgQ  <= strobe.cfgVal;
      if (strobe.stsSet)       stsQ  <= 1'b1;
      else if (strobe.stsClr)  stsQ  <= 1'b0;
    end
  end

  always_comb begin
    regValue         = '0;
    regValue[WPD_B]  = wpdQ;
    regValue[LOCK_B] = lockQ;
    regValue[CFG_HI:CFG_LO] = cfgQ;
    regValue[PRIV_B] = privQ;
    regValue[STS_B]  = stsQ;
    fwWritePermit    = wpdQ && (!privQ || protAttr);
    irqReq           = stsQ;
  end

  // R10: the illegal policy code never reaches storage
  assert_cfg_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ != CFG_BAD);
endmodule

// File: rtl/fwProtReg.sv
module fwProtReg
  import fwProtPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFF = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              privMode,
  input  logic              protAttr,
  input  logic              lockIrqEn,
  output logic [DATA_W-1:0] regValue,
  output logic              fwWritePermit,
  output logic              irqReq
);
  ctlStrobe_t strobe;
  logic       wpdQ;
  logic       lockQ;

  fwProtCtl #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .privMode(privMode), .lockIrqEn(lockIrqEn), .wpdQ(wpdQ), .lockQ(lockQ),
    .strobe(strobe)
  );

  fwProtDp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .protAttr(protAttr),
    .regValue(regValue), .fwWritePermit(fwWritePermit), .irqReq(irqReq),
    .wpdQ(wpdQ), .lockQ(lockQ)
  );

  logic hitTop;
  assign hitTop = wrEn && (addr == REG_OFF);

  // R3: once locked, stays locked until reset
  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    regValue[LOCK_B] |=> regValue[LOCK_B]);
  // R4: non-privileged set attempt under lock leaves protect-disable at 0
  assert_blocked_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hitTop && regValue[LOCK_B] && !privMode && !regValue[WPD_B]) |=> !regValue[WPD_B]);
  // R6: privileged-only enable frozen while locked
  assert_priv_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    regValue[LOCK_B] |=> $stable(regValue[PRIV_B]));
  // R7: interrupt rises only after a blocked attempt with the enable high
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(hitTop && regValue[LOCK_B] && lockIrqEn && !privMode));
  // R11: nothing changes without an addressed write
  assert_no_stray_R11: assert property (@(posedge clk) disable iff (!rstN)
    !hitTop |=> $stable(regValue));
endmodule

// File: tb/fwProtReg_tb.sv
module fwProtReg_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [7:0]  addr;
  logic [31:0] wrData;
  logic        privMode, protAttr, lockIrqEn;
  logic [31:0] regValue;
  logic        fwWritePermit, irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic mWpd, mLock, mPriv, mSts;
  logic [1:0] mCfg;

  always #4 clk = ~clk;

  fwProtReg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .privMode(privMode), .protAttr(protAttr), .lockIrqEn(lockIrqEn),
    .regValue(regValue), .fwWritePermit(fwWritePermit), .irqReq(irqReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mWpd = 0; mLock = 0; mPriv = 1; mSts = 0; mCfg = 2'b00;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; wrEn = 0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic pv, input logic ie, input logic pa);
    logic blk;
    wrEn = wr; addr = a; wrData = d; privMode = pv; lockIrqEn = ie; protAttr = pa;
    @(posedge clk);
    @(negedge clk);
    if (wr && a == 8'hFC) begin
      blk = d[0] && !mWpd && mLock && !pv;
      if (d[0]) mWpd = mWpd | !blk; else mWpd = 1'b0;
      if (blk && ie) mSts = 1'b1; else if (d[6]) mSts = 1'b0;
      if (!mLock) mPriv = d[5];
      if (d[3:2] != 2'b11) mCfg = d[3:2];
      mLock = mLock | d[1];
    end
    wrEn = 0;
  endtask

  function automatic logic [31:0] mVal();
    return {25'b0, mSts, mPriv, 1'b0, mCfg, mLock, mWpd};
  endfunction

  initial begin
    rstN = 0; wrEn = 0; addr = 0; wrData = 0; privMode = 0; protAttr = 0; lockIrqEn = 0;
    modelReset();
    doReset();
    chk("R1 reset value", regValue, 32'h20);
    chk("R1 reset irq", {31'b0, irqReq}, 0);
    chk("R1 reset permit", {31'b0, fwWritePermit}, 0);

    step(1, 8'hF8, 32'h3, 0, 0, 0);
    chk("R11 wrong address", regValue, 32'h20);
    step(0, 8'hFC, 32'h3, 0, 0, 0);
    chk("R11 no strobe", regValue, 32'h20);

    step(1, 8'hFC, 32'hFFFF_FF91, 0, 0, 0);
    chk("R2 reserved ignored", regValue, 32'h01);
    chk("R9 permit bit5 clear", {31'b0, fwWritePermit}, 1);
    step(1, 8'hFC, 32'h20, 0, 0, 0);
    chk("R5 clear unlocked", regValue, 32'h20);

    step(1, 8'hFC, 32'h2C, 0, 0, 0);
    chk("R10 illegal code rejected", regValue, 32'h20);
    step(1, 8'hFC, 32'h28, 0, 0, 0);
    chk("R10 legal code stored", regValue, 32'h28);
    step(1, 8'hFC, 32'h2D, 0, 0, 0);
    chk("R10 illegal keeps old", regValue, 32'h29);

    chk("R9 permit attr low", {31'b0, fwWritePermit}, 0);
    step(0, 8'hFC, 32'h0, 0, 0, 1);
    chk("R9 permit attr high", {31'b0, fwWritePermit}, 1);

    step(1, 8'hFC, 32'h02, 0, 0, 0);
    chk("R3 lock set", regValue, 32'h02);
    step(1, 8'hFC, 32'h22, 0, 0, 0);
    chk("R6 bit5 frozen", regValue, 32'h02);
    step(1, 8'hFC, 32'h00, 0, 0, 0);
    chk("R3 lock not cleared", regValue, 32'h02);

    step(1, 8'hFC, 32'h01, 0, 0, 0);
    chk("R4 blocked no status", regValue, 32'h02);
    chk("R7 no irq when disabled", {31'b0, irqReq}, 0);
    step(1, 8'hFC, 32'h0B, 0, 1, 0);
    chk("R12 cfg updates while blocked", regValue, 32'h4A);
    chk("R8 irq asserted", {31'b0, irqReq}, 1);
    step(1, 8'hFC, 32'h00, 0, 1, 0);
    chk("R8 write 0 keeps status", regValue, 32'h42);
    step(1, 8'hFC, 32'h40, 0, 1, 0);
    chk("R8 write 1 clears", regValue, 32'h02);
    chk("R8 irq deasserted", {31'b0, irqReq}, 0);
    step(1, 8'hFC, 32'h03, 1, 1, 0);
    chk("R4 privileged set", regValue, 32'h03);
    chk("R9 permit locked", {31'b0, fwWritePermit}, 1);
    step(1, 8'hFC, 32'h02, 0, 1, 0);
    chk("R5 clear while locked", regValue, 32'h02);
    step(1, 8'hFC, 32'h41, 0, 1, 0);
    chk("R8 set wins over clear", regValue, 32'h42);

    doReset();
    chk("R3 reset clears lock", regValue, 32'h20);
    step(1, 8'hFC, 32'h21, 0, 1, 0);
    chk("R4 unlocked any access", regValue, 32'h21);
    chk("R7 no irq unlocked", {31'b0, irqReq}, 0);

    begin
      logic [31:0] seed = 32'h1234_5678;
      for (int i = 0; i < 6000; i++) begin
        logic [31:0] r;
        if (i % 40 == 0) doReset();
        seed = seed * 32'd1103515245 + 32'd12345;
        r = seed;
        step(r[20:18] != 0, (r[23:21] == 0) ? 8'hF4 : 8'hFC,
             {r[31:24], 16'h0, r[15], r[6:0]} ^ {24'h0, r[16], 7'h0},
             r[10] & r[11], r[12] | r[13], r[14]);
        chk("R2 R4 R5 R6 R7 R10 R12 sweep value", regValue, mVal());
        chk("R8 sweep irq", {31'b0, irqReq}, {31'b0, mSts});
        chk("R9 sweep permit", {31'b0, fwWritePermit},
            {31'b0, mWpd & (!mPriv | protAttr)});
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule